// File: doc/BRIEF.md
# Windowed Overlay Configuration Bank with Frame-Synchronous Commit

This block stores the setup of five overlay windows for a display scan-out engine. Every window field exists twice. The host bus writes the shadow copy. The scan-out logic reads the active copy. On a vertical sync strobe, each window that is not held copies its whole shadow set into its active set in one cycle. A window's origin, size, base address, format and enable therefore never change in the middle of a frame.

A control register holds two bits per window: a hold bit and a channel-path enable. The host sets the hold bits, updates several registers, and clears the hold bits again. A configuration that is only half written is never committed. A build parameter selects an alternative where one hold bit freezes every window. Either copy of any register can be read back. The inclusive bottom-right corner of each window is derived from its origin and size, and it is driven to the scan-out side.

Top module: `shadow_bank`

## Requirements
- R1: After reset, all shadow fields, active fields, hold bits, channel enables and the commit pulse are zero.
- R2: A bus write changes only the shadow copy. The active outputs and active readback keep their old value until a vsync commit.
- R3: On a cycle with `vsync_i` high, each window that is not held copies enable, format, origin, size and base from shadow to active together. The new active values appear after that clock edge.
- R4: When the hold mode is per window (`GLOBAL_PROTECT`=0), hold bit i in control register bits [4:0] stops only window i from committing at vsync. The other windows still commit.
- R5: Clearing a hold bit commits nothing by itself. The pending shadow values of that window commit at the next vsync.
- R6: When a bus write falls in the same cycle as vsync, the commit uses the shadow and hold values from before the write. The written value waits for the following vsync.
- R7: `xfer_o` is high for exactly one cycle after each vsync edge, with bit i set if and only if window i committed. At all other times it is zero.
- R8: The channel-path enable bits sit in control register bits [12:8]. They reach `chan_en_o` one cycle after the write, without waiting for vsync.
- R9: The corner register (offset 4) reads {y1 at [27:16], x1 at [11:0]}, where x1 = x+w-1 and y1 = y+h-1, floored at zero. The same values drive `act_x1_o` and `act_y1_o`. Writes to offset 4 are ignored.
- R10: When the hold mode is global (`GLOBAL_PROTECT`=1), control bit 0 holds all windows. Control bits [4:1] are stored but have no effect on commits.
- R11: The address is {window[5:3], offset[2:0]}, and the control register sits at window 7, offset 0. The window offsets are: 0 = control (enable bit 0, format bits [3:1]); 1 = origin (x [11:0], y [27:16]); 2 = size (w [11:0], h [27:16]); 3 = base address. Windows 5 and 6, and offsets 5 to 7, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 6 | Write address {window, offset} |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 6 | Read address {window, offset} |
| rd_shadow_i | input | 1 | 1 selects the shadow copy for readback, 0 selects the active copy |
| rd_data_o | output | 32 | Combinational readback |
| vsync_i | input | 1 | Vertical sync strobe; every high cycle is a commit point |
| act_en_o | output | 5 | Active window enables |
| act_fmt_o | output | 15 | Active pixel format codes, 3 bits per window |
| act_x0_o | output | 60 | Active origin x, 12 bits per window |
| act_y0_o | output | 60 | Active origin y, 12 bits per window |
| act_x1_o | output | 60 | Active inclusive right edge, 12 bits per window |
| act_y1_o | output | 60 | Active inclusive bottom edge, 12 bits per window |
| act_base_o | output | 160 | Active base addresses, 32 bits per window |
| chan_en_o | output | 5 | Channel-path enables |
| xfer_o | output | 5 | One-cycle pulse showing which windows committed |

## Verification
A bus write and a vsync commit can fall in the same cycle. The bench provokes this by driving `wr_en_i` and `vsync_i` high together. It does so once with a window register write and once with a write to the hold register. It then judges the result from the active outputs and the commit pulse: the active values must reflect the shadow and hold state from before that edge. The write must become visible only at the next vsync. A behavioural model replays every cycle, including a long pseudo-random stretch where such collisions happen often. The model is compared with both hold-mode variants on every clock.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int unsigned COORD_W  = 12;
  localparam int unsigned FMT_W    = 3;
  localparam int unsigned BASE_W   = 32;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned OFF_W    = 3;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned ADDR_W   = IDX_W + OFF_W;
  localparam int unsigned Y_LSB    = 16;
  localparam int unsigned CHAN_LSB = 8;

  localparam logic [OFF_W-1:0] OFF_CTRL   = 3'd0;
  localparam logic [OFF_W-1:0] OFF_ORIGIN = 3'd1;
  localparam logic [OFF_W-1:0] OFF_SIZE   = 3'd2;
  localparam logic [OFF_W-1:0] OFF_BASE   = 3'd3;
  localparam logic [OFF_W-1:0] OFF_CORNER = 3'd4;
  localparam logic [IDX_W-1:0] GLB_IDX    = 3'd7;

  typedef struct packed {
    logic               en;
    logic [FMT_W-1:0]   fmt;
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
    logic [COORD_W-1:0] w;
    logic [COORD_W-1:0] h;
    logic [BASE_W-1:0]  base;
  } win_cfg_t;

  // inclusive far edge, floored at zero
  function automatic logic [COORD_W-1:0] far_edge(input logic [COORD_W-1:0] pos,
                                                  input logic [COORD_W-1:0] len);
    logic [COORD_W:0] s;
    s = {1'b0, pos} + {1'b0, len};
    if (s == '0) return '0;
    return COORD_W'(s - (COORD_W+1)'(1));
  endfunction
endpackage

// File: rtl/swin_slot.sv
module swin_slot
  import shadow_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              xfer_i,
  output win_cfg_t          shadow_o,
  output win_cfg_t          active_o
);
  win_cfg_t sh_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      if (xfer_i) act_q <= sh_q;  // pre-write shadow on a collision
      if (wr_i) begin
        unique case (wr_off_i)
          OFF_CTRL: begin
            sh_q.en  <= wr_data_i[0];
            sh_q.fmt <= wr_data_i[FMT_W:1];
          end
          OFF_ORIGIN: begin
            sh_q.x <= wr_data_i[COORD_W-1:0];
            sh_q.y <= wr_data_i[Y_LSB +: COORD_W];
          end
          OFF_SIZE: begin
            sh_q.w <= wr_data_i[COORD_W-1:0];
            sh_q.h <= wr_data_i[Y_LSB +: COORD_W];
          end
          OFF_BASE: sh_q.base <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  assign shadow_o = sh_q;
  assign active_o = act_q;

  p_active_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(act_q));
  p_commit_whole_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> act_q == $past(sh_q));
endmodule

// File: rtl/sbank_ctrl.sv
module sbank_ctrl #(
  parameter int unsigned NWIN           = 5,
  parameter bit          GLOBAL_PROTECT = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [NWIN-1:0] wr_prot_i,
  input  logic [NWIN-1:0] wr_chan_i,
  input  logic            vsync_i,
  output logic [NWIN-1:0] prot_o,
  output logic [NWIN-1:0] chan_o,
  output logic [NWIN-1:0] xfer_o,
  output logic [NWIN-1:0] pulse_o
);
  logic [NWIN-1:0] prot_q, chan_q, pulse_q, prot_eff;

  generate
    if (GLOBAL_PROTECT) begin : g_global
      assign prot_eff = {NWIN{prot_q[0]}};
      p_global_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vsync_i && prot_q[0] |=> pulse_q == '0);
    end else begin : g_per_win
      assign prot_eff = prot_q;
      p_win_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vsync_i |=> (pulse_q & $past(prot_q)) == '0);
    end
  endgenerate

  assign xfer_o = vsync_i ? ~prot_eff : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q  <= '0;
      chan_q  <= '0;
      pulse_q <= '0;
    end else begin
      pulse_q <= xfer_o;
      if (wr_i) begin
        prot_q <= wr_prot_i;
        chan_q <= wr_chan_i;
      end
    end
  end

  assign prot_o  = prot_q;
  assign chan_o  = chan_q;
  assign pulse_o = pulse_q;

  p_quiet_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> pulse_q == '0);
  p_chan_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(chan_q));
endmodule

// File: rtl/sbank_rdmux.sv
module sbank_rdmux
  import shadow_bank_pkg::*;
#(
  parameter int unsigned NWIN = 5
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_shadow_i,
  input  win_cfg_t          sh_i  [NWIN],
  input  win_cfg_t          act_i [NWIN],
  input  logic [NWIN-1:0]   prot_i,
  input  logic [NWIN-1:0]   chan_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [IDX_W-1:0] ridx;
  logic [OFF_W-1:0] roff;
  win_cfg_t         c;

  assign ridx = rd_addr_i[ADDR_W-1:OFF_W];
  assign roff = rd_addr_i[OFF_W-1:0];

  always_comb begin
    rd_data_o = '0;
    c = '0;
    if (ridx == GLB_IDX) begin
      if (roff == OFF_CTRL) begin
        rd_data_o[NWIN-1:0]         = prot_i;
        rd_data_o[CHAN_LSB +: NWIN] = chan_i;
      end
    end else begin
      for (int i = 0; i < NWIN; i++) begin
        if (ridx == IDX_W'(i)) c = rd_shadow_i ? sh_i[i] : act_i[i];
      end
      unique case (roff)
        OFF_CTRL: begin
          rd_data_o[0]       = c.en;
          rd_data_o[FMT_W:1] = c.fmt;
        end
        OFF_ORIGIN: begin
          rd_data_o[COORD_W-1:0]      = c.x;
          rd_data_o[Y_LSB +: COORD_W] = c.y;
        end
        OFF_SIZE: begin
          rd_data_o[COORD_W-1:0]      = c.w;
          rd_data_o[Y_LSB +: COORD_W] = c.h;
        end
        OFF_BASE: rd_data_o = c.base;
        OFF_CORNER: begin
          rd_data_o[COORD_W-1:0]      = far_edge(c.x, c.w);
          rd_data_o[Y_LSB +: COORD_W] = far_edge(c.y, c.h);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int unsigned NWIN           = 5,
  parameter bit          GLOBAL_PROTECT = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  input  logic                     rd_shadow_i,
  output logic [DATA_W-1:0]        rd_data_o,
  input  logic                     vsync_i,
  output logic [NWIN-1:0]          act_en_o,
  output logic [NWIN*FMT_W-1:0]    act_fmt_o,
  output logic [NWIN*COORD_W-1:0]  act_x0_o,
  output logic [NWIN*COORD_W-1:0]  act_y0_o,
  output logic [NWIN*COORD_W-1:0]  act_x1_o,
  output logic [NWIN*COORD_W-1:0]  act_y1_o,
  output logic [NWIN*BASE_W-1:0]   act_base_o,
  output logic [NWIN-1:0]          chan_en_o,
  output logic [NWIN-1:0]          xfer_o
);
  logic [IDX_W-1:0] w_idx;
  logic [OFF_W-1:0] w_off;
  logic             ctrl_wr;
  logic [NWIN-1:0]  commit, prot;
  win_cfg_t         sh  [NWIN];
  win_cfg_t         act [NWIN];

  assign w_idx   = wr_addr_i[ADDR_W-1:OFF_W];
  assign w_off   = wr_addr_i[OFF_W-1:0];
  assign ctrl_wr = wr_en_i && (w_idx == GLB_IDX) && (w_off == OFF_CTRL);

  sbank_ctrl #(.NWIN(NWIN), .GLOBAL_PROTECT(GLOBAL_PROTECT)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_wr),
    .wr_prot_i (wr_data_i[NWIN-1:0]),
    .wr_chan_i (wr_data_i[CHAN_LSB +: NWIN]),
    .vsync_i   (vsync_i),
    .prot_o    (prot),
    .chan_o    (chan_en_o),
    .xfer_o    (commit),
    .pulse_o   (xfer_o)
  );

  generate
    for (genvar i = 0; i < NWIN; i++) begin : g_win
      logic slot_wr;
      assign slot_wr = wr_en_i && (w_idx == IDX_W'(i)) && (w_off < OFF_CORNER);

      swin_slot u_slot (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (slot_wr),
        .wr_off_i  (w_off),
        .wr_data_i (wr_data_i),
        .xfer_i    (commit[i]),
        .shadow_o  (sh[i]),
        .active_o  (act[i])
      );

      assign act_en_o[i]                      = act[i].en;
      assign act_fmt_o[i*FMT_W +: FMT_W]      = act[i].fmt;
      assign act_x0_o[i*COORD_W +: COORD_W]   = act[i].x;
      assign act_y0_o[i*COORD_W +: COORD_W]   = act[i].y;
      assign act_x1_o[i*COORD_W +: COORD_W]   = far_edge(act[i].x, act[i].w);
      assign act_y1_o[i*COORD_W +: COORD_W]   = far_edge(act[i].y, act[i].h);
      assign act_base_o[i*BASE_W +: BASE_W]   = act[i].base;
    end
  endgenerate

  sbank_rdmux #(.NWIN(NWIN)) u_rdmux (
    .rd_addr_i   (rd_addr_i),
    .rd_shadow_i (rd_shadow_i),
    .sh_i        (sh),
    .act_i       (act),
    .prot_i      (prot),
    .chan_i      (chan_en_o),
    .rd_data_o   (rd_data_o)
  );

  p_pulse_after_vsync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o != '0) |-> $past(vsync_i));
  p_enable_frame_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> $stable(act_en_o));
endmodule

// File: tb/shadow_bank_bench.sv
`timescale 1ns/1ps
module shadow_bank_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic        rd_shadow = 1'b0;
  logic        vsync = 1'b0;

  logic [31:0]  b_rd   [2];
  logic [4:0]   b_en   [2];
  logic [14:0]  b_fmt  [2];
  logic [59:0]  b_x0   [2];
  logic [59:0]  b_y0   [2];
  logic [59:0]  b_x1   [2];
  logic [59:0]  b_y1   [2];
  logic [159:0] b_base [2];
  logic [4:0]   b_ch   [2];
  logic [4:0]   b_xf   [2];

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  shadow_bank #(.NWIN(5), .GLOBAL_PROTECT(1'b0)) u_shadow_bank (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_shadow_i(rd_shadow),
    .rd_data_o(b_rd[0]), .vsync_i(vsync), .act_en_o(b_en[0]),
    .act_fmt_o(b_fmt[0]), .act_x0_o(b_x0[0]), .act_y0_o(b_y0[0]),
    .act_x1_o(b_x1[0]), .act_y1_o(b_y1[0]), .act_base_o(b_base[0]),
    .chan_en_o(b_ch[0]), .xfer_o(b_xf[0]));

  shadow_bank #(.NWIN(5), .GLOBAL_PROTECT(1'b1)) u_shadow_bank_glb (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_shadow_i(rd_shadow),
    .rd_data_o(b_rd[1]), .vsync_i(vsync), .act_en_o(b_en[1]),
    .act_fmt_o(b_fmt[1]), .act_x0_o(b_x0[1]), .act_y0_o(b_y0[1]),
    .act_x1_o(b_x1[1]), .act_y1_o(b_y1[1]), .act_base_o(b_base[1]),
    .chan_en_o(b_ch[1]), .xfer_o(b_xf[1]));

  // reference model: [variant][window][offset 0..3]
  logic [31:0] m_sh [2][5][4];
  logic [31:0] m_ac [2][5][4];
  logic [4:0]  m_prot [2];
  logic [4:0]  m_chan [2];
  logic [4:0]  m_xfer [2];

  function automatic logic [11:0] fe(input logic [11:0] p, input logic [11:0] l);
    int s;
    s = int'(p) + int'(l);
    return (s == 0) ? 12'd0 : 12'(s - 1);
  endfunction

  function automatic logic [5:0] adr(input int w, input int o);
    return {3'(w), 3'(o)};
  endfunction

  function automatic logic [31:0] model_rd(input int v, input logic [5:0] a, input bit shd);
    int w, o;
    logic [31:0] r [4];
    w = int'(a[5:3]);
    o = int'(a[2:0]);
    if (w == 7) return (o == 0) ? {19'd0, m_chan[v], 3'd0, m_prot[v]} : 32'd0;
    if (w > 4) return 32'd0;
    for (int k = 0; k < 4; k++) r[k] = shd ? m_sh[v][w][k] : m_ac[v][w][k];
    if (o < 4) return r[o];
    if (o == 4) return {4'd0, fe(r[1][27:16], r[2][27:16]), 4'd0, fe(r[1][11:0], r[2][11:0])};
    return 32'd0;
  endfunction

  task automatic model_reset();
    for (int v = 0; v < 2; v++) begin
      m_prot[v] = '0; m_chan[v] = '0; m_xfer[v] = '0;
      for (int w = 0; w < 5; w++)
        for (int k = 0; k < 4; k++) begin m_sh[v][w][k] = '0; m_ac[v][w][k] = '0; end
    end
  endtask

  task automatic model_step();
    int w, o;
    for (int v = 0; v < 2; v++) begin
      m_xfer[v] = '0;
      if (vsync) begin
        for (int i = 0; i < 5; i++) begin
          bit hold;
          hold = (v == 0) ? m_prot[v][i] : m_prot[v][0];
          if (!hold) begin
            for (int k = 0; k < 4; k++) m_ac[v][i][k] = m_sh[v][i][k];
            m_xfer[v][i] = 1'b1;
          end
        end
      end
      if (wr_en) begin
        w = int'(wr_addr[5:3]);
        o = int'(wr_addr[2:0]);
        if (w < 5 && o < 4) begin
          case (o)
            0: m_sh[v][w][o] = wr_data & 32'h0000_000F;
            1, 2: m_sh[v][w][o] = wr_data & 32'h0FFF_0FFF;
            default: m_sh[v][w][o] = wr_data;
          endcase
        end else if (w == 7 && o == 0) begin
          m_prot[v] = wr_data[4:0];
          m_chan[v] = wr_data[12:8];
        end
      end
    end
  endtask

  task automatic chk(input string tag, input logic [127:0] a, input logic [127:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic compare_all();
    for (int v = 0; v < 2; v++) begin
      for (int w = 0; w < 5; w++) begin
        logic [127:0] a, e;
        a = {44'd0, b_en[v][w], b_fmt[v][w*3 +: 3], b_x0[v][w*12 +: 12], b_y0[v][w*12 +: 12],
             b_x1[v][w*12 +: 12], b_y1[v][w*12 +: 12], b_base[v][w*32 +: 32]};
        e = {44'd0, m_ac[v][w][0][0], m_ac[v][w][0][3:1], m_ac[v][w][1][11:0], m_ac[v][w][1][27:16],
             fe(m_ac[v][w][1][11:0], m_ac[v][w][2][11:0]),
             fe(m_ac[v][w][1][27:16], m_ac[v][w][2][27:16]), m_ac[v][w][3]};
        chk($sformatf("R3 R9 active window %0d variant %0d", w, v), a, e);
      end
      chk($sformatf("R7 pulse variant %0d", v), 128'(b_xf[v]), 128'(m_xfer[v]));
      chk($sformatf("R8 channel variant %0d", v), 128'(b_ch[v]), 128'(m_chan[v]));
    end
  endtask

  task automatic tick(input bit we, input logic [5:0] a, input logic [31:0] d, input bit vs);
    wr_en = we; wr_addr = a; wr_data = d; vsync = vs;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    wr_en = 1'b0; vsync = 1'b0;
  endtask

  task automatic rdchk(input logic [5:0] a, input bit shd, input string tag);
    rd_addr = a; rd_shadow = shd;
    #0.5;
    for (int v = 0; v < 2; v++) chk($sformatf("%s variant %0d", tag, v), 128'(b_rd[v]), 128'(model_rd(v, a, shd)));
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #0.5;
    compare_all();                              // R1
    rdchk(adr(2, 1), 1'b1, "R1 reset shadow origin");
    rdchk(adr(7, 0), 1'b1, "R1 reset control");
    chk("R1 reset pulse", 128'(b_xf[0]), 128'd0);

    // R2: shadow-only writes to window 2
    tick(1, adr(2, 1), {4'd0, 12'd20, 4'd0, 12'd10}, 0);
    tick(1, adr(2, 2), {4'd0, 12'd5, 4'd0, 12'd30}, 0);
    tick(1, adr(2, 3), 32'h8000_1000, 0);
    tick(1, adr(2, 0), 32'h0000_000B, 0);
    rdchk(adr(2, 1), 1'b1, "R2 shadow origin");
    rdchk(adr(2, 1), 1'b0, "R2 active origin unchanged");
    chk("R2 enable not yet active", 128'(b_en[0][2]), 128'd0);
    rd_addr = adr(2, 4); rd_shadow = 1'b1; #0.5;
    chk("R9 shadow corner literal", 128'(b_rd[0]), 128'({4'd0, 12'd24, 4'd0, 12'd39}));

    // R3 commit, R7 pulse
    tick(0, '0, '0, 1);
    chk("R7 pulse lists all windows", 128'(b_xf[0]), 128'(5'b11111));
    chk("R3 enable committed", 128'(b_en[0][2]), 128'd1);
    chk("R9 active right edge", 128'(b_x1[0][2*12 +: 12]), 128'd39);
    rdchk(adr(2, 3), 1'b0, "R3 active base");
    tick(0, '0, '0, 0);
    chk("R7 pulse lasts one cycle", 128'(b_xf[0]), 128'd0);

    // R4 / R8 / R10: hold window 1
    tick(1, adr(7, 0), {19'd0, 5'b10101, 3'd0, 5'b00010}, 0);
    chk("R8 channel immediate", 128'(b_ch[0]), 128'(5'b10101));
    tick(1, adr(1, 1), {4'd0, 12'd3, 4'd0, 12'd4}, 0);
    tick(1, adr(3, 1), {4'd0, 12'd6, 4'd0, 12'd7}, 0);
    tick(0, '0, '0, 1);
    chk("R4 held window skipped", 128'(b_xf[0]), 128'(5'b11101));
    chk("R10 upper hold bits ignored", 128'(b_xf[1]), 128'(5'b11111));
    chk("R4 held origin stays", 128'(b_x0[0][1*12 +: 12]), 128'd0);
    rdchk(adr(3, 1), 1'b0, "R4 free window committed");

    // R5: release commits only at next vsync
    tick(1, adr(7, 0), {19'd0, 5'b10101, 3'd0, 5'b00000}, 0);
    chk("R5 release alone commits nothing", 128'(b_x0[0][1*12 +: 12]), 128'd0);
    rdchk(adr(1, 1), 1'b0, "R5 active before vsync");
    tick(0, '0, '0, 1);
    chk("R5 pending value committed", 128'(b_x0[0][1*12 +: 12]), 128'd4);

    // R6: data write colliding with vsync
    tick(1, adr(0, 1), {4'd0, 12'd8, 4'd0, 12'd7}, 0);
    tick(1, adr(0, 1), {4'd0, 12'd9, 4'd0, 12'd9}, 1);
    chk("R6 commit uses pre-write shadow", 128'(b_x0[0][11:0]), 128'd7);
    rdchk(adr(0, 1), 1'b1, "R6 new value in shadow");
    tick(0, '0, '0, 1);
    chk("R6 new value at next vsync", 128'(b_x0[0][11:0]), 128'd9);

    // R6: hold write colliding with vsync uses old hold
    tick(1, adr(0, 2), {4'd0, 12'd4, 4'd0, 12'd4}, 0);
    tick(1, adr(7, 0), 32'h0000_0001, 1);
    chk("R6 old hold used per-window", 128'(b_xf[0][0]), 128'd1);
    chk("R6 old hold used global", 128'(b_xf[1][0]), 128'd1);
    rdchk(adr(7, 0), 1'b1, "R6 hold stored");

    // R10: bit 0 freezes all in global variant
    tick(1, adr(0, 3), 32'h1234_5678, 0);
    tick(1, adr(4, 3), 32'h9ABC_DEF0, 0);
    tick(0, '0, '0, 1);
    chk("R4 only window 0 held", 128'(b_xf[0]), 128'(5'b11110));
    chk("R10 global hold freezes all", 128'(b_xf[1]), 128'd0);

    // R9 / R11 corner cases
    tick(1, adr(7, 0), 32'h0, 0);
    rdchk(adr(4, 4), 1'b1, "R9 floored corner");
    chk("R9 floored literal", 128'(b_rd[0]), 128'd0);
    tick(1, adr(4, 4), 32'hFFFF_FFFF, 0);
    rdchk(adr(4, 4), 1'b1, "R11 corner write ignored");
    tick(1, adr(5, 1), 32'hFFFF_FFFF, 0);
    rdchk(adr(5, 1), 1'b1, "R11 unmapped window");
    chk("R11 unmapped literal", 128'(b_rd[0]), 128'd0);
    rdchk(adr(2, 6), 1'b0, "R11 reserved offset");
    rdchk(adr(3, 2), 1'b1, "R11 size field position");

    // mixed traffic with frequent write/vsync collisions
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] d;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      d = {lf, lf ^ 16'h5A5A};
      tick(lf[0] | lf[1], lf[7:2], d, lf[11] & lf[12]);
      rdchk(lf[13:8], lf[14], "R11 mixed readback");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule